// File: doc/BRIEF.md
# Dual-Rail Zero-Wave Logic Slice

This block is a logic slice for datapaths that must resist power analysis. Each single-rail operand bit is turned into a rail pair, a true rail and a false rail. All logic between the input encoders and the output decoders is built from two non-inverting primitives. A dual-rail AND drives its true rail with the AND of the true rails and its false rail with the OR of the false rails. A dual-rail OR is the mirror image. Inversion never uses an inverter: the two rails of a pair are swapped. In every cycle, each pair therefore has exactly one rail high (evaluate) or both rails low (precharge).

The control input `precharge` selects the phase. While it is high, the encoders force every input pair to 0/0, and the zero moves gate by gate through the network, so every internal pair is 0/0. While it is low, the slice computes two word results:
- the bitwise XOR of two operands;
- that XOR combined with a third operand by AND or by OR. A dual-rail select input chooses which.

Decoders turn the result pairs back into single-rail bits and flag any pair that is not complementary. The block captures the decoded values in every evaluate cycle. It presents them on its output registers only on the evaluate-to-precharge transition, so downstream logic never sees a half-evaluated word.

Top module: `zw_logic_slice`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `xor_q`, `mix_q`, `valid_q` and `code_err_q` are all 0.
- R2: After an evaluation with operands A and B, `xor_q` equals A XOR B.
- R3: After an evaluation, `mix_q` equals (A XOR B) OR C when `or_mode` was 1, and (A XOR B) AND C when `or_mode` was 0.
- R4: Outputs change only at the first clock edge where `precharge` is sampled high after an edge where it was sampled low. They hold through evaluate cycles and through repeated precharge cycles.
- R5: Operand and mode values presented while `precharge` is high have no effect on any output.
- R6: In every precharge cycle, every encoded input pair and every internal and result rail pair is 0/0.
- R7: In every evaluate cycle, every rail pair has exactly one rail high. After an evaluation `valid_q` is 1 and `code_err_q` is 0.
- R8: When evaluation lasts several cycles, the operands of the last evaluate cycle before precharge decide the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| precharge | input | 1 | 1 = precharge phase, 0 = evaluate phase |
| op_a | input | W | First XOR operand |
| op_b | input | W | Second XOR operand |
| op_c | input | W | Operand for the AND/OR stage |
| or_mode | input | 1 | 1 = OR stage, 0 = AND stage |
| xor_q | output | W | Registered A XOR B |
| mix_q | output | W | Registered AND/OR stage result |
| valid_q | output | 1 | A complementary evaluation has been presented |
| code_err_q | output | 1 | The presented evaluation contained a non-complementary pair |

## Verification
An operand set is driven on a falling edge with `precharge` low. The next rising edge stages the decoded values. The following falling edge raises `precharge`, and the rising edge after that loads the outputs. Results are therefore due two rising edges after the stimulus, and the bench samples them on the falling edge that follows, away from any active edge. Hold checks look at the outputs on falling edges inside evaluate and repeated precharge windows. At those points the values must still be those of the previous transition, even though new or garbage operands are applied.

// File: rtl/zw_pkg.sv
package zw_pkg;

    // One dual-rail signal: logical 1 = t high, logical 0 = f high, 0/0 = precharge
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    typedef enum logic {
        GATE_AND = 1'b0,
        GATE_OR  = 1'b1
    } gate_kind_e;

    // Logical inversion by exchanging the rails
    function automatic rail_t rail_swap(input rail_t r);
        rail_t s;
        s.t = r.f;
        s.f = r.t;
        return s;
    endfunction

endpackage

// File: rtl/zw_encoder.sv
module zw_encoder
    import zw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           precharge,
    input  logic [W-1:0]   bits_i,
    output rail_t [W-1:0]  rails_o
);

    // Only place where an inverter is allowed: building the false rail
    always_comb begin
        for (int i = 0; i < W; i++) begin
            rails_o[i].t = ~precharge &  bits_i[i];
            rails_o[i].f = ~precharge & ~bits_i[i];
        end
    end

    a_r5_gate_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        precharge |-> (rails_o == '0));

endmodule

// File: rtl/zw_rail_gate.sv
module zw_rail_gate
    import zw_pkg::*;
#(
    parameter gate_kind_e KIND = GATE_AND
) (
    input  rail_t a_i,
    input  rail_t b_i,
    output rail_t y_o
);

    generate
        if (KIND == GATE_AND) begin : g_and
            assign y_o.t = a_i.t & b_i.t;
            assign y_o.f = a_i.f | b_i.f;
        end else begin : g_or
            assign y_o.t = a_i.t | b_i.t;
            assign y_o.f = a_i.f & b_i.f;
        end
    endgenerate

endmodule

// File: rtl/zw_rail_xor.sv
module zw_rail_xor
    import zw_pkg::*;
(
    input  rail_t a_i,
    input  rail_t b_i,
    output rail_t y_o
);

    // y = (a & ~b) | (~a & b); true rail carries XOR, false rail XNOR
    rail_t left_w;
    rail_t right_w;

    zw_rail_gate #(.KIND(GATE_AND)) u_left (
        .a_i(a_i), .b_i(rail_swap(b_i)), .y_o(left_w));
    zw_rail_gate #(.KIND(GATE_AND)) u_right (
        .a_i(rail_swap(a_i)), .b_i(b_i), .y_o(right_w));
    zw_rail_gate #(.KIND(GATE_OR)) u_join (
        .a_i(left_w), .b_i(right_w), .y_o(y_o));

endmodule

// File: rtl/zw_rail_select.sv
module zw_rail_select
    import zw_pkg::*;
(
    input  rail_t sel_i,
    input  rail_t one_i,
    input  rail_t zero_i,
    output rail_t y_o
);

    // y = (sel & one) | (~sel & zero), all in dual rail
    rail_t pick_one_w;
    rail_t pick_zero_w;

    zw_rail_gate #(.KIND(GATE_AND)) u_one (
        .a_i(sel_i), .b_i(one_i), .y_o(pick_one_w));
    zw_rail_gate #(.KIND(GATE_AND)) u_zero (
        .a_i(rail_swap(sel_i)), .b_i(zero_i), .y_o(pick_zero_w));
    zw_rail_gate #(.KIND(GATE_OR)) u_join (
        .a_i(pick_one_w), .b_i(pick_zero_w), .y_o(y_o));

endmodule

// File: rtl/zw_decoder.sv
module zw_decoder
    import zw_pkg::*;
#(
    parameter int W = 32
) (
    input  rail_t [W-1:0] rails_i,
    output logic  [W-1:0] bits_o,
    output logic          bad_o,
    output logic          idle_o
);

    always_comb begin
        bad_o  = 1'b0;
        idle_o = 1'b1;
        for (int i = 0; i < W; i++) begin
            bits_o[i] = rails_i[i].t;
            bad_o     = bad_o  | ~(rails_i[i].t ^ rails_i[i].f);
            idle_o    = idle_o & ~(rails_i[i].t | rails_i[i].f);
        end
    end

endmodule

// File: rtl/zw_logic_slice.sv
module zw_logic_slice
    import zw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         precharge,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic         or_mode,
    output logic [W-1:0] xor_q,
    output logic [W-1:0] mix_q,
    output logic         valid_q,
    output logic         code_err_q
);

    typedef struct packed {
        logic         phase;
        logic [W-1:0] stage_xor;
        logic [W-1:0] stage_mix;
        logic         stage_err;
        logic [W-1:0] out_xor;
        logic [W-1:0] out_mix;
        logic         out_valid;
        logic         out_err;
    } state_t;

    state_t st_d, st_q;

    rail_t [W-1:0] a_r, b_r, c_r;
    rail_t [0:0]   sel_r;
    rail_t [W-1:0] xor_r, and_r, or_r, mix_r;

    zw_encoder #(.W(W)) u_enc_a (.clk(clk), .rst_n(rst_n), .precharge(precharge),
        .bits_i(op_a), .rails_o(a_r));
    zw_encoder #(.W(W)) u_enc_b (.clk(clk), .rst_n(rst_n), .precharge(precharge),
        .bits_i(op_b), .rails_o(b_r));
    zw_encoder #(.W(W)) u_enc_c (.clk(clk), .rst_n(rst_n), .precharge(precharge),
        .bits_i(op_c), .rails_o(c_r));
    zw_encoder #(.W(1)) u_enc_sel (.clk(clk), .rst_n(rst_n), .precharge(precharge),
        .bits_i(or_mode), .rails_o(sel_r));

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            zw_rail_xor u_xor (.a_i(a_r[i]), .b_i(b_r[i]), .y_o(xor_r[i]));
            zw_rail_gate #(.KIND(GATE_AND)) u_and (
                .a_i(xor_r[i]), .b_i(c_r[i]), .y_o(and_r[i]));
            zw_rail_gate #(.KIND(GATE_OR)) u_or (
                .a_i(xor_r[i]), .b_i(c_r[i]), .y_o(or_r[i]));
            zw_rail_select u_sel (.sel_i(sel_r[0]), .one_i(or_r[i]),
                .zero_i(and_r[i]), .y_o(mix_r[i]));
        end
    endgenerate

    logic [W-1:0] dec_xor, dec_mix;
    logic         bad_xor, bad_mix, idle_xor, idle_mix;

    zw_decoder #(.W(W)) u_dec_xor (.rails_i(xor_r), .bits_o(dec_xor),
        .bad_o(bad_xor), .idle_o(idle_xor));
    zw_decoder #(.W(W)) u_dec_mix (.rails_i(mix_r), .bits_o(dec_mix),
        .bad_o(bad_mix), .idle_o(idle_mix));

    always_comb begin
        st_d       = st_q;
        st_d.phase = precharge;
        if (!precharge) begin
            st_d.stage_xor = dec_xor;
            st_d.stage_mix = dec_mix;
            st_d.stage_err = bad_xor | bad_mix;
        end
        if (precharge && !st_q.phase) begin
            st_d.out_xor   = st_q.stage_xor;
            st_d.out_mix   = st_q.stage_mix;
            st_d.out_err   = st_q.stage_err;
            st_d.out_valid = ~st_q.stage_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign xor_q      = st_q.out_xor;
    assign mix_q      = st_q.out_mix;
    assign valid_q    = st_q.out_valid;
    assign code_err_q = st_q.out_err;

    // R6: the zero wave reaches every result pair in precharge
    a_r6_zero_wave: assert property (@(posedge clk) disable iff (!rst_n)
        precharge |-> (idle_xor && idle_mix && and_r == '0 && or_r == '0));

    // R7: evaluation yields complementary pairs everywhere
    a_r7_complementary: assert property (@(posedge clk) disable iff (!rst_n)
        !precharge |-> (!bad_xor && !bad_mix));

    a_r7_no_err_out: assert property (@(posedge clk) disable iff (!rst_n)
        !code_err_q);

    // R4: outputs stay put except on the evaluate-to-precharge edge
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(precharge && !st_q.phase) |=> ($stable(xor_q) && $stable(mix_q)));

endmodule

// File: tb/zw_logic_slice_tb.sv
module zw_logic_slice_tb;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         precharge = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic         or_mode = 1'b0;
    logic [W-1:0] xor_q, mix_q;
    logic         valid_q, code_err_q;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    zw_logic_slice #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .precharge(precharge),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .or_mode(or_mode),
        .xor_q(xor_q), .mix_q(mix_q), .valid_q(valid_q), .code_err_q(code_err_q));

    // {a, b, c, or_mode}
    localparam logic [3*W:0] VEC [8] = '{
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
        {32'hA5A5_A5A5, 32'h5A5A_5A5A, 32'h0F0F_0F0F, 1'b0},
        {32'h1234_5678, 32'h9ABC_DEF0, 32'hF0F0_0000, 1'b1},
        {32'hDEAD_BEEF, 32'hCAFE_F00D, 32'h00FF_00FF, 1'b0},
        {32'h8000_0001, 32'h0000_0001, 32'h7FFF_FFFE, 1'b1},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'h5555_5555, 1'b1}
    };

    function automatic logic [W-1:0] ref_mix(logic [W-1:0] a, logic [W-1:0] b,
                                             logic [W-1:0] c, logic om);
        return om ? ((a ^ b) | c) : ((a ^ b) & c);
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one evaluate cycle then precharge with garbage; sample after the load
    task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c, logic om);
        @(negedge clk);
        precharge = 1'b0; op_a = a; op_b = b; op_c = c; or_mode = om;
        @(negedge clk);
        precharge = 1'b1; op_a = ~a; op_b = $urandom; op_c = ~c; or_mode = ~om;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] ea, eb, ec;
        logic         eo;
        // R1 reset state
        @(negedge clk);
        check("R1 xor", xor_q, '0);
        check("R1 mix", mix_q, '0);
        check("R1 valid", {31'b0, valid_q}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {xor_q[30:0], valid_q}, '0);

        // R2/R3/R7 table walk
        for (int i = 0; i < 8; i++) begin
            {ea, eb, ec, eo} = VEC[i];
            run_op(ea, eb, ec, eo);
            check("R2 xor", xor_q, ea ^ eb);
            check("R3 mix", mix_q, ref_mix(ea, eb, ec, eo));
            check("R7 valid/err", {30'b0, valid_q, code_err_q}, 32'd2);
        end

        // R2/R3 random operands
        for (int i = 0; i < 20; i++) begin
            ea = $urandom; eb = $urandom; ec = $urandom; eo = i[0];
            run_op(ea, eb, ec, eo);
            check("R2 rand xor", xor_q, ea ^ eb);
            check("R3 rand mix", mix_q, ref_mix(ea, eb, ec, eo));
        end

        // R4 hold through evaluate cycles with new operands
        ea = 32'h0F0F_1234; eb = 32'h00FF_4321; ec = 32'hFFFF_0000; eo = 1'b1;
        run_op(ea, eb, ec, eo);
        precharge = 1'b0; op_a = 32'h1111_1111; op_b = 32'h2222_2222;
        @(negedge clk);
        @(negedge clk);
        check("R4 hold in evaluate xor", xor_q, ea ^ eb);
        check("R4 hold in evaluate mix", mix_q, ref_mix(ea, eb, ec, eo));

        // R8 last evaluate cycle wins
        op_a = 32'hCAFE_0000; op_b = 32'h0000_BABE; op_c = 32'h0F0F_0F0F; or_mode = 1'b0;
        @(negedge clk);
        precharge = 1'b1;
        @(negedge clk);
        check("R8 last eval xor", xor_q, 32'hCAFE_BABE);
        check("R8 last eval mix", mix_q, 32'hCAFE_BABE & 32'h0F0F_0F0F);

        // R5 and R4: long precharge with changing garbage leaves outputs alone
        for (int i = 0; i < 6; i++) begin
            op_a = $urandom; op_b = $urandom; op_c = $urandom; or_mode = i[0];
            @(negedge clk);
        end
        check("R5 precharge ignored xor", xor_q, 32'hCAFE_BABE);
        check("R5 precharge ignored mix", mix_q, 32'hCAFE_BABE & 32'h0F0F_0F0F);

        // R6 checked by assertions throughout; one more mode flip at boundary
        run_op(32'h0, 32'h0, 32'hFFFF_FFFF, 1'b1);
        check("R3 or with zero xor", mix_q, 32'hFFFF_FFFF);
        check("R6 R7 no error flag", {31'b0, code_err_q}, '0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule